// File: doc/BRIEF.md
# UART FIFO DMA Request Generator

This block drives the two DMA request lines of a buffered UART, one for receive and one for transmit. It does not move data. It watches the occupancy counts of the receive and transmit FIFOs and a one-cycle receive timeout pulse. It is steered by static configuration pins:

- buffer depth: 16 or 64 entries;
- a 2-bit receive trigger level code;
- a DMA mode bit;
- a DMA access width bit, for one-byte or two-byte transfers.

Each request is held in a flip-flop. One condition sets it and a different condition releases it, so between the two events the line keeps its state. A DMA controller watches the lines and moves data while the line it serves is high.

All pins are plain control and status signals. There is no data stream, so there is no valid/ready handshake and no back-pressure. The occupancy counts are level inputs and are sampled every cycle. Both outputs are registered, so a change on an input shows at the outputs one clock edge later.

Top module: `uart_dma_req_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, both `rx_dma_req` and `tx_dma_req` are low after that edge.
- R2: The receive trigger level code `rx_trig_sel` selects the threshold as follows. With `deep_mode`=0, codes 0, 1, 2 and 3 give 1, 4, 8 and 14 bytes. With `deep_mode`=1, the same codes give 1, 16, 32 and 56 bytes.
- R3: With one-byte width (`wide_xfer`=0) and mode 0 (`dma_mode`=0), `rx_dma_req` is set when `rx_level` ≥ 1 and is released when `rx_level` = 0.
- R4: With one-byte width and mode 1, `rx_dma_req` is set when `rx_level` reaches the trigger level or `rx_timeout` is high. It is released when `rx_level` = 0.
- R5: With two-byte width (`wide_xfer`=1) and mode 0, `rx_dma_req` is set when `rx_level` ≥ 2 and is released when `rx_level` ≤ 1.
- R6: With two-byte width and mode 1, `rx_dma_req` is set when the trigger level is reached or `rx_timeout` is high, but only while `rx_level` ≥ 2. It is released when `rx_level` ≤ 1.
- R7: In mode 0, `tx_dma_req` is set when `tx_level` = 0. It is released when `tx_level` ≥ 1 at one-byte width, or when `tx_level` ≥ 2 at two-byte width.
- R8: In mode 1, at either width, `tx_dma_req` is set when `tx_level` = 0. It is released only when `tx_level` equals the selected depth, which is 16 or 64.
- R9: When the set and release conditions of a request are both true in the same cycle, the request ends low. One example is `rx_timeout` arriving while the receive FIFO is empty.
- R10: If any configuration input differs from its value at the previous edge, both requests are low after the edge. Normal evaluation resumes at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rx_level | input | CNT_W (7) | Receive FIFO occupancy, 0 to depth |
| tx_level | input | CNT_W (7) | Transmit FIFO occupancy, 0 to depth |
| rx_timeout | input | 1 | One-cycle receive timeout pulse |
| deep_mode | input | 1 | 0: 16-entry FIFOs, 1: 64-entry FIFOs |
| rx_trig_sel | input | 2 | Receive trigger level code |
| dma_mode | input | 1 | DMA mode 0 or 1 |
| wide_xfer | input | 1 | 0: one-byte access, 1: two-byte access |
| rx_dma_req | output | 1 | Registered receive DMA request |
| tx_dma_req | output | 1 | Registered transmit DMA request |

## Verification
The properties assume that each occupancy count stays within 0 to the selected depth. They also assume the timeout pulse comes from the receive side and is not tied to a configuration change. The stimulus limits every count to the current depth, and it moves counts by small steps with occasional jumps to empty or full. Configuration changes are spaced well apart and are held for many cycles, so that each mode has time to show both its set and its release transitions. The timeout is pulsed in every receive mode, including while the receive FIFO is empty.

// File: rtl/dmareq_pkg.sv
package dmareq_pkg;
  typedef struct packed {
    logic       deep;
    logic [1:0] trig;
    logic       mode;
    logic       wide;
  } dma_cfg_t;

  typedef enum logic {
    MODE_LEVEL  = 1'b0,
    MODE_BURST  = 1'b1
  } dma_mode_e;
endpackage

// File: rtl/trig_level_lut.sv
module trig_level_lut #(
  parameter int CNT_W = 7
) (
  input  logic             deep,
  input  logic [1:0]       code,
  output logic [CNT_W-1:0] level
);
  always_comb begin
    unique case ({deep, code})
      3'b000:  level = CNT_W'(1);
      3'b001:  level = CNT_W'(4);
      3'b010:  level = CNT_W'(8);
      3'b011:  level = CNT_W'(14);
      3'b100:  level = CNT_W'(1);
      3'b101:  level = CNT_W'(16);
      3'b110:  level = CNT_W'(32);
      default: level = CNT_W'(56);
    endcase
  end
endmodule

// File: rtl/cfg_watch.sv
module cfg_watch
  import dmareq_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  dma_cfg_t cfg,
  output logic     changed
);
  dma_cfg_t cfg_q;

  always_ff @(posedge clk) begin
    cfg_q <= cfg;
  end

  assign changed = !rst && (cfg != cfg_q);
endmodule

// File: rtl/req_flop.sv
module req_flop (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic set_cond,
  input  logic rel_cond,
  output logic req
);
  always_ff @(posedge clk) begin
    if (rst || clear || rel_cond) req <= 1'b0;
    else if (set_cond)            req <= 1'b1;
  end
endmodule

// File: rtl/uart_dma_req_gen.sv
module uart_dma_req_gen
  import dmareq_pkg::*;
#(
  parameter int SHALLOW_DEPTH = 16,
  parameter int DEEP_DEPTH    = 64,
  parameter int CNT_W         = $clog2(DEEP_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] rx_level,
  input  logic [CNT_W-1:0] tx_level,
  input  logic             rx_timeout,
  input  logic             deep_mode,
  input  logic [1:0]       rx_trig_sel,
  input  logic             dma_mode,
  input  logic             wide_xfer,
  output logic             rx_dma_req,
  output logic             tx_dma_req
);
  localparam logic [CNT_W-1:0] SHALLOW_FULL = CNT_W'(SHALLOW_DEPTH);
  localparam logic [CNT_W-1:0] DEEP_FULL    = CNT_W'(DEEP_DEPTH);

  dma_cfg_t         cfg;
  logic             cfg_changed;
  logic [CNT_W-1:0] trig_level;
  logic [CNT_W-1:0] min_bytes;
  logic [CNT_W-1:0] full_level;
  logic             rx_set, rx_rel, tx_set, tx_rel;

  assign cfg = '{deep: deep_mode, trig: rx_trig_sel, mode: dma_mode, wide: wide_xfer};

  cfg_watch u_watch (
    .clk     (clk),
    .rst     (rst),
    .cfg     (cfg),
    .changed (cfg_changed)
  );

  trig_level_lut #(.CNT_W(CNT_W)) u_lut (
    .deep  (deep_mode),
    .code  (rx_trig_sel),
    .level (trig_level)
  );

  assign min_bytes  = wide_xfer ? CNT_W'(2) : CNT_W'(1);
  assign full_level = deep_mode ? DEEP_FULL : SHALLOW_FULL;

  always_comb begin
    rx_rel = rx_level < min_bytes;
    if (dma_mode_e'(dma_mode) == MODE_LEVEL) begin
      rx_set = rx_level >= min_bytes;
      tx_rel = tx_level >= min_bytes;
    end else begin
      rx_set = (wide_xfer ? (rx_level >= min_bytes) : 1'b1)
               && ((rx_level >= trig_level) || rx_timeout);
      tx_rel = tx_level == full_level;
    end
    tx_set = tx_level == '0;
  end

  req_flop u_rx (
    .clk      (clk),
    .rst      (rst),
    .clear    (cfg_changed),
    .set_cond (rx_set),
    .rel_cond (rx_rel),
    .req      (rx_dma_req)
  );

  req_flop u_tx (
    .clk      (clk),
    .rst      (rst),
    .clear    (cfg_changed),
    .set_cond (tx_set),
    .rel_cond (tx_rel),
    .req      (tx_dma_req)
  );
endmodule

// File: rtl/uart_dma_req_chk.sv
module uart_dma_req_chk #(
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] rx_level,
  input logic [CNT_W-1:0] tx_level,
  input logic             rx_timeout,
  input logic             deep_mode,
  input logic [1:0]       rx_trig_sel,
  input logic             dma_mode,
  input logic             wide_xfer,
  input logic             rx_dma_req,
  input logic             tx_dma_req
);
  logic [4:0] cfg_now;
  logic       past_valid;
  assign cfg_now = {deep_mode, rx_trig_sel, dma_mode, wide_xfer};

  always_ff @(posedge clk) begin
    if (rst) past_valid <= 1'b1;
  end

  assert_rx_empty_R3: assert property (@(posedge clk) disable iff (rst)
    (rx_level == '0) |=> !rx_dma_req);

  assert_rx_wide_low_R5: assert property (@(posedge clk) disable iff (rst)
    (wide_xfer && rx_level < 2) |=> !rx_dma_req);

  assert_tx_byte_rel_R7: assert property (@(posedge clk) disable iff (rst)
    (!dma_mode && !wide_xfer && tx_level != '0) |=> !tx_dma_req);

  assert_tx_empty_set_R8: assert property (@(posedge clk) disable iff (rst || !past_valid)
    (tx_level == '0 && $stable(cfg_now)) |=> tx_dma_req);

  assert_tx_full_rel_R8: assert property (@(posedge clk) disable iff (rst)
    (dma_mode && tx_level == (deep_mode ? 7'd64 : 7'd16)) |=> !tx_dma_req);

  assert_timeout_empty_R9: assert property (@(posedge clk) disable iff (rst)
    (rx_timeout && rx_level == '0) |=> !rx_dma_req);

  assert_cfg_clear_R10: assert property (@(posedge clk) disable iff (rst || !past_valid)
    !$stable(cfg_now) |=> (!rx_dma_req && !tx_dma_req));
endmodule

bind uart_dma_req_gen uart_dma_req_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_uart_dma_req_gen.sv
module sim_uart_dma_req_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] rx_level = '0, tx_level = '0;
  logic       rx_timeout = 1'b0;
  logic       deep_mode = 1'b0, dma_mode = 1'b0, wide_xfer = 1'b0;
  logic [1:0] rx_trig_sel = 2'd0;
  logic       rx_dma_req, tx_dma_req;

  int tests = 0, fails = 0;
  bit done = 0;
  bit m_rx = 0, m_tx = 0;
  logic [4:0] m_pcfg = '0;
  string force_tag = "";

  int lv16[4] = '{1, 4, 8, 14};
  int lv64[4] = '{1, 16, 32, 56};

  always #5 clk = ~clk;

  uart_dma_req_gen u0 (.*);

  // behavioural reference, evaluated from the requirements
  always @(posedge clk) begin
    int mn, trig, full, rxc, txc;
    logic [4:0] c;
    bit rs, rr, ts, tr;
    c = {deep_mode, rx_trig_sel, dma_mode, wide_xfer};
    rxc = int'(rx_level); txc = int'(tx_level);
    mn = wide_xfer ? 2 : 1;
    trig = deep_mode ? lv64[rx_trig_sel] : lv16[rx_trig_sel];
    full = deep_mode ? 64 : 16;
    if (rst) begin
      m_rx <= 0; m_tx <= 0;
    end else if (c != m_pcfg) begin
      m_rx <= 0; m_tx <= 0;
    end else begin
      rr = rxc < mn;
      if (!dma_mode) rs = rxc >= mn;
      else rs = (rxc >= trig || rx_timeout) && (rxc >= mn);
      if (!wide_xfer && dma_mode) rs = rxc >= trig || rx_timeout;
      ts = txc == 0;
      tr = dma_mode ? (txc == full) : (txc >= mn);
      m_rx <= rr ? 1'b0 : (rs ? 1'b1 : m_rx);
      m_tx <= tr ? 1'b0 : (ts ? 1'b1 : m_tx);
    end
    m_pcfg <= c;
  end

  task automatic cyc();
    string rt, tt;
    @(negedge clk);
    rt = dma_mode ? (wide_xfer ? "R6" : "R4") : (wide_xfer ? "R5" : "R3");
    tt = dma_mode ? "R8" : "R7";
    if (force_tag != "") begin rt = force_tag; tt = force_tag; end
    tests++;
    if (rx_dma_req !== m_rx || tx_dma_req !== m_tx) begin
      fails++;
      if (rx_dma_req !== m_rx)
        $display("FAIL %s rx_dma_req actual %b expected %b (rx_level=%0d)", rt, rx_dma_req, m_rx, rx_level);
      if (tx_dma_req !== m_tx)
        $display("FAIL %s tx_dma_req actual %b expected %b (tx_level=%0d)", tt, tx_dma_req, m_tx, tx_level);
    end
  endtask

  task automatic set_cfg(bit d, bit [1:0] t, bit m, bit w);
    deep_mode = d; rx_trig_sel = t; dma_mode = m; wide_xfer = w;
    force_tag = "R10"; cyc(); force_tag = ""; cyc();
  endtask

  task automatic rx_ramp(int top);
    for (int i = 0; i <= top; i++) begin rx_level = 7'(i); cyc(); end
    for (int i = top; i >= 0; i--) begin rx_level = 7'(i); cyc(); end
  endtask

  task automatic tx_ramp(int top);
    for (int i = 0; i <= top; i++) begin tx_level = 7'(i); cyc(); end
    for (int i = top; i >= 0; i--) begin tx_level = 7'(i); cyc(); end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int depth;
    force_tag = "R1";
    rx_level = 7'd5; tx_level = 7'd0;
    cyc(); cyc();
    rst = 1'b0; rx_level = 7'd0;
    force_tag = ""; cyc(); cyc();

    // R3 / R7 byte mode 0
    rx_ramp(3); tx_ramp(3);
    // R5 / R7 wide mode 0
    set_cfg(0, 0, 0, 1); rx_ramp(4); tx_ramp(4);
    // R2 / R4 / R8 all trigger codes, both depths, byte mode 1
    for (int d = 0; d < 2; d++)
      for (int t = 0; t < 4; t++) begin
        set_cfg(d[0], t[1:0], 1, 0);
        depth = d ? 64 : 16;
        force_tag = "R2"; rx_ramp(depth); force_tag = "";
        tx_ramp(depth);
      end
    // R6 wide mode 1 with trigger code 0 (level 1 must still need two bytes)
    set_cfg(0, 0, 1, 1); rx_ramp(3); tx_ramp(16);
    set_cfg(1, 2, 1, 1); rx_ramp(40); tx_ramp(64);
    // R4 / R6 / R9 timeouts at various fills
    for (int w = 0; w < 2; w++) begin
      set_cfg(0, 3, 1, w[0]);
      for (int f = 0; f < 4; f++) begin
        rx_level = 7'(f); cyc();
        rx_timeout = 1; if (f == 0) force_tag = "R9"; cyc();
        rx_timeout = 0; force_tag = ""; cyc(); cyc();
      end
      rx_level = 0; cyc();
    end
    // R10 change while requests are high
    set_cfg(0, 0, 0, 0); rx_level = 7'd3; tx_level = 7'd0; cyc(); cyc();
    set_cfg(0, 0, 0, 1); cyc();
    set_cfg(1, 0, 0, 1); cyc();

    // mixed random stimulus
    for (int n = 0; n < 4000; n++) begin
      depth = deep_mode ? 64 : 16;
      if ($urandom_range(0, 60) == 0) begin
        deep_mode = 1'($urandom); rx_trig_sel = 2'($urandom);
        dma_mode = 1'($urandom); wide_xfer = 1'($urandom);
        depth = deep_mode ? 64 : 16;
      end
      case ($urandom_range(0, 9))
        0: rx_level = 0;
        1: tx_level = 7'(depth);
        2: tx_level = 0;
        default: begin
          rx_level = 7'($urandom_range(0, 2) + int'(rx_level));
          if (int'(rx_level) >= 2 && $urandom_range(0, 1) == 1) rx_level = rx_level - 7'd2;
          tx_level = 7'($urandom_range(0, 2) + int'(tx_level));
          if (int'(tx_level) >= 2 && $urandom_range(0, 1) == 1) tx_level = tx_level - 7'd2;
        end
      endcase
      if (int'(rx_level) > depth) rx_level = 7'(depth);
      if (int'(tx_level) > depth) tx_level = 7'(depth);
      rx_timeout = ($urandom_range(0, 15) == 0);
      cyc();
    end
    rx_timeout = 0;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule